// File: doc/BRIEF.md
# Fractional one-second event generator

This block turns a cycle-rate enable into one-second events whose long-term count is exact, even when the length of a second is not a whole number of coarse ticks. A free-running prescaler and a wrap counter divide the enabled cycles into a coarse tick of fixed length. A wide error accumulator starts at the cycles-per-second constant, and each coarse tick takes one tick length off it. When a tick finds less than one tick length left, the block marks a second. It adds the reload constant to the leftover rather than overwriting it, so the fraction carries into the next second.

Individual seconds therefore differ by one tick, but no error builds up over time. With the default settings a tick is 512 cycles and the reload is 1,000,000. The pattern repeats every eight seconds: seven seconds of 999,936 cycles and one of 1,000,448. Calibration is done by writing a new reload value into a trim register, and that value is used from the next reload on. A consumer sees either a one-cycle pulse or a sticky flag, which it clears itself.

Top module: `sec_tick_gen`

## Requirements
- R1: While reset is held and right after it is released, `coarse_tick`, `sec_pulse` and `sec_flag` are 0. Reset sets the trim register and the accumulator to `RELOAD_DEFAULT`.
- R2: `coarse_tick` is high in exactly one of every `PRESCALE*WRAP` cycles that have `cyc_en` high, counted from reset. It is never high in a cycle with `cyc_en` low, and such a cycle does not advance the count. No write or clear input resets this count.
- R3: Let T be the tick length and S1 the reload value loaded at reset. S(j+1) is S(j) plus the trim value in force at the j-th second event. The j-th second event occurs on coarse tick number floor(S(j)/T)+1, counting ticks from 1 after reset. This follows from carrying the leftover into every reload.
- R4: Each second lasts either floor(R/T) or floor(R/T)+1 coarse ticks, where R is the reload value that started it. The first second after reset counts as started by `RELOAD_DEFAULT`. With the defaults this gives seconds of 1953 or 1954 ticks.
- R5: With a constant reload R, the span from any second event to the eighth event after it is exactly 8*R/T ticks whenever 8*R is a multiple of T. The default 1,000,000 with T = 512 is such a case.
- R6: `sec_pulse` is high for one cycle, only in a cycle in which `coarse_tick` is also high. That is the cycle whose clock edge performs the reload.
- R7: `sec_flag` becomes 1 on the clock edge that ends a `sec_pulse` cycle. It then stays 1 until a cycle with `flag_clr` high and no `sec_pulse`, and it goes to 0 on that cycle's edge.
- R8: When `flag_clr` and `sec_pulse` are high in the same cycle, `sec_flag` is 1 after that edge.
- R9: A trim written with `trim_wr` takes effect at the next reload edge after the write edge. The second in progress still ends on the tick set by the earlier reload values.
- R10: A reset after trim writes restores `RELOAD_DEFAULT`. The first event after that reset occurs on tick floor(`RELOAD_DEFAULT`/T)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One counted cycle when high |
| trim_wr | input | 1 | Load `trim_val` into the trim register |
| trim_val | input | ACC_W | New reload constant (must be at least the tick length) |
| flag_clr | input | 1 | Clear the sticky second flag |
| coarse_tick | output | 1 | High in the enabled cycle that ends a coarse tick |
| sec_pulse | output | 1 | High in the cycle that ends a second |
| sec_flag | output | 1 | Sticky second flag |

## Verification
The hardest case to reach from the ports is a trim write that lands in the middle of a second. The second in progress must keep its old end while the next second takes the new length. Another hard case is a clear that arrives in the very cycle of a reload. The bench uses a small configuration with 8-cycle ticks and a 12-bit accumulator. It sweeps reload values from exactly one tick up to about 25 ticks, writing each one at an arbitrary point inside a second, and predicts every event tick from the running sum of reload values. One phase holds the clear input high through several reloads while `cyc_en` is gated, which produces the clear-versus-set collision without any need to aim for it.

// File: rtl/sec_tick_pkg.sv
package sec_tick_pkg;

    // Width of a counter that holds 0 .. n-1, never less than one bit
    function automatic int unsigned cnt_width(input int unsigned n);
        cnt_width = (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Registered state of the sticky event flag
    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/sec_tick_base.sv
module sec_tick_base #(
    parameter int unsigned PRESCALE = 2,
    parameter int unsigned WRAP     = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    output logic tick
);
    import sec_tick_pkg::*;

    localparam int unsigned PRE_W = cnt_width(PRESCALE);
    localparam int unsigned CNT_W = cnt_width(WRAP);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRAP - 1);

    logic             pre_wrap;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Prescaler variant picked by the ratio; it is only ever cleared by reset
    generate
        if (PRESCALE > 1) begin : g_pre
            logic [PRE_W-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (cyc_en) begin
                    pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign pre_wrap = (pre_q == PRE_LAST);
        end else begin : g_nopre
            assign pre_wrap = 1'b1;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (cyc_en && pre_wrap) begin
            cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = cyc_en && pre_wrap && (cnt_q == CNT_LAST);

endmodule

// File: rtl/sec_frac_accum.sv
module sec_frac_accum #(
    parameter int unsigned ACC_W          = 24,
    parameter int unsigned TICK_LEN       = 512,
    parameter int unsigned RELOAD_DEFAULT = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trim_wr,
    input  logic [ACC_W-1:0] trim_val,
    output logic             sec_evt
);
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_LEN);
    localparam logic [ACC_W-1:0] RLD_0 = ACC_W'(RELOAD_DEFAULT);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] trim;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic       evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (trim_wr) begin
            st_d.trim = trim_val;
        end
        if (tick) begin
            if (st_q.acc < STEP) begin
                // Leftover is kept; result is below trim, so modular math is exact
                evt_d    = 1'b1;
                st_d.acc = st_q.acc + st_q.trim - STEP;
            end else begin
                st_d.acc = st_q.acc - STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc  <= RLD_0;
            st_q.trim <= RLD_0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_evt = evt_d;

endmodule

// File: rtl/sec_event_flag.sv
module sec_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    import sec_tick_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)     st_d.flag = 1'b0;
        if (set_evt) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
    parameter int unsigned PRESCALE       = 2,
    parameter int unsigned WRAP           = 256,
    parameter int unsigned ACC_W          = 24,
    parameter int unsigned RELOAD_DEFAULT = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             trim_wr,
    input  logic [ACC_W-1:0] trim_val,
    input  logic             flag_clr,
    output logic             coarse_tick,
    output logic             sec_pulse,
    output logic             sec_flag
);
    localparam int unsigned TICK_LEN = PRESCALE * WRAP;

    logic tick_w;
    logic evt_w;

    sec_tick_base #(
        .PRESCALE (PRESCALE),
        .WRAP     (WRAP)
    ) i_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .tick   (tick_w)
    );

    sec_frac_accum #(
        .ACC_W          (ACC_W),
        .TICK_LEN       (TICK_LEN),
        .RELOAD_DEFAULT (RELOAD_DEFAULT)
    ) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .trim_wr  (trim_wr),
        .trim_val (trim_val),
        .sec_evt  (evt_w)
    );

    sec_event_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt_w),
        .clr     (flag_clr),
        .flag    (sec_flag)
    );

    assign coarse_tick = tick_w;
    assign sec_pulse   = evt_w;

endmodule

// File: rtl/sec_tick_gen_chk.sv
module sec_tick_gen_chk #(
    parameter int unsigned TICK_LEN = 512
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_en,
    input logic flag_clr,
    input logic coarse_tick,
    input logic sec_pulse,
    input logic sec_flag
);
    // Enabled cycles seen since the last coarse tick
    logic [31:0] en_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           en_cnt <= '0;
        else if (coarse_tick) en_cnt <= '0;
        else if (cyc_en)      en_cnt <= en_cnt + 1;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_tick |-> (en_cnt == 32'(TICK_LEN - 1)));

    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |-> !coarse_tick);

    a_r6_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> coarse_tick);

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> sec_flag);

    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_flag && !flag_clr) |=> sec_flag);

    a_r7_rise_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_flag) |-> $past(sec_pulse));

    a_r8_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !sec_pulse) |=> !sec_flag);

endmodule

bind sec_tick_gen sec_tick_gen_chk #(
    .TICK_LEN (TICK_LEN)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_en      (cyc_en),
    .flag_clr    (flag_clr),
    .coarse_tick (coarse_tick),
    .sec_pulse   (sec_pulse),
    .sec_flag    (sec_flag)
);

// File: tb/test_sec_tick_gen.sv
module test_sec_tick_gen;

    localparam int PRE   = 2;
    localparam int WRP   = 4;
    localparam int TICK  = PRE * WRP;
    localparam int AW    = 12;
    localparam int RDEF  = 100;
    localparam int CYC   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_en = 1'b0;
    logic          trim_wr = 1'b0;
    logic [AW-1:0] trim_val = '0;
    logic          flag_clr = 1'b0;
    logic          coarse_tick, sec_pulse, sec_flag;

    always #(CYC/2) clk = ~clk;

    sec_tick_gen #(
        .PRESCALE (PRE), .WRAP (WRP), .ACC_W (AW), .RELOAD_DEFAULT (RDEF)
    ) i_sec_tick_gen (
        .clk (clk), .rst_n (rst_n), .cyc_en (cyc_en),
        .trim_wr (trim_wr), .trim_val (trim_val), .flag_clr (flag_clr),
        .coarse_tick (coarse_tick), .sec_pulse (sec_pulse), .sec_flag (sec_flag)
    );

    int     n_chk = 0, n_fail = 0;
    longint en_total, tick_total, s_sum, last_evt, t_first, t_ninth;
    int     trim_model, r_cur, sec_count, obs_count;
    bit     flag_model, pend_r8;
    string  ptag = "R3 event tick";
    logic [7:0] lf = 8'h5a;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        en_total = 0; tick_total = 0; s_sum = RDEF; last_evt = 0;
        trim_model = RDEF; r_cur = RDEF; sec_count = 0; obs_count = 0;
        flag_model = 0; pend_r8 = 0; t_first = 0; t_ninth = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cyc_en = 1'b0; trim_wr = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        #1;
        chk(coarse_tick == 0, "R1 tick in reset", coarse_tick, 0);
        chk(sec_pulse == 0, "R1 pulse in reset", sec_pulse, 0);
        chk(sec_flag == 0, "R1 flag in reset", sec_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic step(input bit en, input bit wr, input int val, input bit clr);
        bit     exp_tick, exp_pulse;
        longint len;
        @(negedge clk);
        cyc_en = en; trim_wr = wr; trim_val = AW'(val); flag_clr = clr;
        #1;
        exp_tick = en && (((en_total + 1) % TICK) == 0);
        chk(coarse_tick == exp_tick, "R2 coarse tick", coarse_tick, exp_tick);
        exp_pulse = 0;
        if (exp_tick) exp_pulse = ((tick_total + 1) == (s_sum / TICK) + 1);
        chk(sec_pulse == exp_pulse, exp_tick ? ptag : "R6 pulse outside reload tick",
            sec_pulse, exp_pulse);
        chk(sec_flag == flag_model, pend_r8 ? "R8 set beats clear" : "R7 sticky flag",
            sec_flag, flag_model);
        if (sec_pulse && coarse_tick) begin
            len = tick_total + 1 - last_evt;
            chk(len == r_cur / TICK || len == r_cur / TICK + 1, "R4 second length",
                len, r_cur / TICK);
            obs_count++;
            if (obs_count == 1) t_first = tick_total + 1;
            if (obs_count == 9) t_ninth = tick_total + 1;
            last_evt = tick_total + 1;
        end
        if (en) en_total++;
        if (exp_tick) tick_total++;
        pend_r8 = clr && exp_pulse;
        if (exp_pulse) begin
            s_sum += trim_model;
            r_cur = trim_model;
            sec_count++;
        end
        flag_model = exp_pulse | (flag_model & !clr);
        if (wr) trim_model = val;
    endtask

    initial begin
        #(CYC * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        step(0, 0, 0, 0);
        chk(sec_flag == 0, "R1 flag after reset", sec_flag, 0);

        // Default reload, full-rate enable, occasional clears
        begin
            int c = 0;
            while (sec_count < 10) begin
                step(1, 0, 0, (c % 37) == 0);
                c++;
            end
        end
        chk((t_ninth - t_first) * TICK == 8 * RDEF, "R5 eight-second span",
            (t_ninth - t_first) * TICK, 8 * RDEF);

        // Gated enable with clear held high through several reloads
        for (int i = 0; i < 500; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[1:0] != 2'b00, 0, 0, 1);
        end

        // Trim sweep: write lands mid-second, new length from the next reload
        ptag = "R9 event tick after trim";
        for (int r = TICK; r <= 200; r += 11) begin
            int target;
            target = sec_count + 4;
            for (int k = 0; k < (r % 5) + 2; k++) step(1, 0, 0, 0);
            step(1, 1, r, 0);
            while (sec_count < target) step(1, 0, 0, (sec_count % 2) == 0);
        end
        begin
            int target;
            target = sec_count + 4;
            step(1, 1, 64, 0);
            while (sec_count < target) step(1, 0, 0, 0);
        end

        // Reset after a trim write restores the default reload
        step(1, 1, 40, 0);
        do_reset();
        ptag = "R10 event tick after reset";
        while (sec_count < 3) step(1, 0, 0, 0);
        chk(t_first == RDEF / TICK + 1, "R10 first event tick", t_first, RDEF / TICK + 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule